// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block runs on the master clock of an audio converter that is operating as a slave to an external word clock. It counts the master clock cycles in each word-clock period. It then sorts that count into one of six supported oversampling ratios and drives a ratio code. The ratio code selects the oversampling rate of the downstream digital filters.

The word clock arrives asynchronously. It is synchronised, and its rising edges mark the period boundaries. Each measured period is compared against every supported ratio with a fixed tolerance. A count that matches no ratio, or that overflows the counter, selects the slowest ratio and raises a fallback flag. A new code reaches the outputs only when two periods in a row give the same result. This rejects single glitched periods.

Top module: `mclk_ratio_detect`

## Requirements
- R1: The word clock input passes through a two-flop synchroniser. A period is the number of master clock cycles from one synchronised rising edge to the next. The very first rising edge after reset only starts the measurement.
- R2: Ratio codes are 0=128, 1=192, 2=256, 3=384, 4=512 and 5=768 master clocks per word-clock period.
- R3: A period count C is classified as ratio N when |C - N| <= 32, with the bound included. When C lies within tolerance of two ratios (160 or 224), the smaller ratio wins.
- R4: A count farther than 32 from every ratio classifies as code 5 with the error marker set. When such a result is committed, the fallback flag is 1.
- R5: The period counter saturates at 1023. A saturated count, for example from a 1100-cycle period, is classified as an error.
- R6: A classification is committed only when it equals the classification of the immediately preceding period. Alternating results leave the committed code unchanged.
- R7: Out of reset, ratio_code is 5, ratio_valid is 0 and ratio_fallback is 0. ratio_valid stays 0 until the first commit and then stays 1.
- R8: osr_half is 1 (64x oversampling) when the committed code is 0 or 1. It is 0 (128x) for every other code.
- R9: A genuine 768 match (count 736 to 800) commits code 5 with ratio_fallback equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lrc_async | input | 1 | Word clock, asynchronous to clk_mst |
| ratio_code | output | 3 | Committed ratio code (R2 encoding) |
| ratio_valid | output | 1 | A ratio has been committed since reset |
| ratio_fallback | output | 1 | Committed code is the error default |
| osr_half | output | 1 | 1 selects 64x oversampling, 0 selects 128x |

## Verification
The assertions assume that the word clock is a plain slave-mode square wave: one rising edge per period and never a period shorter than the synchroniser plus edge-detect latency. Under that assumption the committed code can change only while ratio_valid is set, and a fallback result always carries the default code. The bench drives the word clock on the falling edge of the master clock, so every synchronised period equals the driven length exactly. Each driven period is at least 64 cycles long, which keeps every rising edge well clear of the pipeline. The stimulus sweeps period lengths across the whole range and lands exactly on each tolerance boundary.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
   typedef enum logic [2:0] {
      RATIO_128 = 3'd0,
      RATIO_192 = 3'd1,
      RATIO_256 = 3'd2,
      RATIO_384 = 3'd3,
      RATIO_512 = 3'd4,
      RATIO_768 = 3'd5
   } mrd_ratio_e;

   localparam int NUM_RATIOS = 6;

   // Nominal master clocks per period for ratio index i: 128 * 2^(i/2), times 1.5 for odd i.
   function automatic int ratio_nominal(input int i);
      int base;
      base = 128 << (i / 2);
      return (i % 2 == 1) ? (base * 3) / 2 : base;
   endfunction
endpackage

// File: rtl/mrd_edge_sync.sv
module mrd_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   localparam int W = STAGES + 1;
   logic [W-1:0] shreg;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mrd_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[W-2:0], din};
   end

   assign rise = shreg[W-2] & ~shreg[W-1];
endmodule

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   output logic             sample_stb,
   output logic [CNT_W-1:0] sample_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt;
   logic             armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         armed      <= 1'b0;
         sample_stb <= 1'b0;
         sample_cnt <= '0;
      end else if (rise) begin
         cnt        <= CNT_ONE;
         armed      <= 1'b1;
         sample_stb <= armed;
         sample_cnt <= cnt;
      end else begin
         sample_stb <= 1'b0;
         if (cnt != CNT_MAX) cnt <= cnt + CNT_ONE;
      end
   end
endmodule

// File: rtl/mrd_classifier.sv
module mrd_classifier
   import mrd_pkg::*;
#(
   parameter int CNT_W = 10,
   parameter int TOL   = 32
) (
   input  logic [CNT_W-1:0] count,
   output mrd_ratio_e       code,
   output logic             err
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [NUM_RATIOS-1:0] hit;

   generate
      for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
         localparam int NOM = ratio_nominal(i);
         always_comb begin
            hit[i] = (int'(count) + TOL >= NOM) && (int'(count) <= NOM + TOL);
         end
      end
   endgenerate

   always_comb begin
      code = RATIO_768;
      for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
         if (hit[i]) code = mrd_ratio_e'(i);
      end
      err = (hit == '0) || (count == CNT_MAX);
      if (err) code = RATIO_768;
   end
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
   import mrd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 10,
   parameter int TOL         = 32
) (
   input  logic       clk_mst,
   input  logic       rst_n,
   input  logic       lrc_async,
   output logic [2:0] ratio_code,
   output logic       ratio_valid,
   output logic       ratio_fallback,
   output logic       osr_half
);
   generate
      if ((1 << CNT_W) - 1 <= ratio_nominal(NUM_RATIOS - 1) + TOL) begin : g_bad_width
         $error("mclk_ratio_detect: CNT_W too small for the largest ratio window");
      end
      if (TOL < 1 || TOL >= 64) begin : g_bad_tol
         $error("mclk_ratio_detect: TOL out of range");
      end
   endgenerate

   logic             rise;
   logic             sample_stb;
   logic [CNT_W-1:0] sample_cnt;
   mrd_ratio_e       cls_code;
   logic             cls_err;

   mrd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk_mst),
      .rst_n(rst_n),
      .din  (lrc_async),
      .rise (rise)
   );

   mrd_period_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk_mst),
      .rst_n     (rst_n),
      .rise      (rise),
      .sample_stb(sample_stb),
      .sample_cnt(sample_cnt)
   );

   mrd_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
      .count(sample_cnt),
      .code (cls_code),
      .err  (cls_err)
   );

   mrd_ratio_e prev_code;
   logic       prev_err;
   logic       prev_ok;
   mrd_ratio_e cur_code;

   always_ff @(posedge clk_mst or negedge rst_n) begin
      if (!rst_n) begin
         prev_code      <= RATIO_768;
         prev_err       <= 1'b0;
         prev_ok        <= 1'b0;
         cur_code       <= RATIO_768;
         ratio_valid    <= 1'b0;
         ratio_fallback <= 1'b0;
      end else if (sample_stb) begin
         prev_code <= cls_code;
         prev_err  <= cls_err;
         prev_ok   <= 1'b1;
         if (prev_ok && (prev_code == cls_code) && (prev_err == cls_err)) begin
            cur_code       <= cls_code;
            ratio_fallback <= cls_err;
            ratio_valid    <= 1'b1;
         end
      end
   end

   assign ratio_code = cur_code;
   assign osr_half   = (cur_code == RATIO_128) || (cur_code == RATIO_192);
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker (
   input logic       clk_mst,
   input logic       rst_n,
   input logic [2:0] ratio_code,
   input logic       ratio_valid,
   input logic       ratio_fallback,
   input logic       osr_half
);
   AST_CODE_LEGAL: assert property (@(posedge clk_mst) disable iff (!rst_n)
      ratio_code <= 3'd5); // R2
   AST_FALLBACK_DEFAULT: assert property (@(posedge clk_mst) disable iff (!rst_n)
      ratio_fallback |-> (ratio_code == 3'd5)); // R4
   AST_FALLBACK_NEEDS_VALID: assert property (@(posedge clk_mst) disable iff (!rst_n)
      ratio_fallback |-> ratio_valid); // R4
   AST_VALID_STICKY: assert property (@(posedge clk_mst) disable iff (!rst_n)
      ratio_valid |=> ratio_valid); // R7
   AST_CODE_HELD_UNTIL_VALID: assert property (@(posedge clk_mst) disable iff (!rst_n)
      !ratio_valid |-> (ratio_code == 3'd5)); // R7
   AST_HALF_NOT_FALLBACK: assert property (@(posedge clk_mst) disable iff (!rst_n)
      osr_half |-> !ratio_fallback); // R8
   AST_CODE_MOVES_VALID: assert property (@(posedge clk_mst) disable iff (!rst_n)
      !$stable(ratio_code) |-> ratio_valid); // R6
endmodule

bind mclk_ratio_detect mrd_checker u_chk (
   .clk_mst       (clk_mst),
   .rst_n         (rst_n),
   .ratio_code    (ratio_code),
   .ratio_valid   (ratio_valid),
   .ratio_fallback(ratio_fallback),
   .osr_half      (osr_half)
);

// File: tb/mclk_ratio_detect_test.sv
module mclk_ratio_detect_test;
   logic       clk_mst = 1'b0;
   logic       rst_n   = 1'b0;
   logic       lrc_async = 1'b0;
   logic [2:0] ratio_code;
   logic       ratio_valid;
   logic       ratio_fallback;
   logic       osr_half;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   always #10 clk_mst = ~clk_mst;

   mclk_ratio_detect uut (
      .clk_mst       (clk_mst),
      .rst_n         (rst_n),
      .lrc_async     (lrc_async),
      .ratio_code    (ratio_code),
      .ratio_valid   (ratio_valid),
      .ratio_fallback(ratio_fallback),
      .osr_half      (osr_half)
   );

   // Expected classification from R2..R5
   function automatic void expect_of(input int p, output int code, output bit fb);
      int noms[6] = '{128, 192, 256, 384, 512, 768};
      int c;
      c = (p > 1023) ? 1023 : p;
      code = 5;
      fb   = 1'b1;
      if (c != 1023) begin
         for (int i = 5; i >= 0; i--) begin
            if (c >= noms[i] - 32 && c <= noms[i] + 32) begin
               code = i;
               fb   = 1'b0;
            end
         end
      end
   endfunction

   task automatic one_period(input int p);
      lrc_async = 1'b1;
      repeat (p / 2) @(negedge clk_mst);
      lrc_async = 1'b0;
      repeat (p - p / 2) @(negedge clk_mst);
   endtask

   task automatic check(input string req, input int ecode, input bit evalid,
                        input bit efb, input bit eosr);
      vectors++;
      if (ratio_code !== 3'(ecode) || ratio_valid !== evalid ||
          ratio_fallback !== efb || osr_half !== eosr) begin
         fails++;
         $display("FAIL %s: got code=%0d valid=%0b fb=%0b osr=%0b, expected code=%0d valid=%0b fb=%0b osr=%0b",
                  req, ratio_code, ratio_valid, ratio_fallback, osr_half,
                  ecode, evalid, efb, eosr);
      end
   endtask

   task automatic apply_and_check(input int p, input string req);
      int  ec;
      bit  ef;
      repeat (3) one_period(p);
      expect_of(p, ec, ef);
      check(req, ec, 1'b1, ef, (ec <= 1));
   endtask

   initial begin
      int bnd[28] = '{95, 96, 128, 160, 161, 192, 224, 225, 256, 288, 289,
                      351, 352, 384, 416, 417, 479, 480, 512, 544, 545,
                      735, 736, 768, 800, 801, 1023, 1100};
      repeat (3) @(negedge clk_mst);
      check("R7 reset", 5, 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk_mst);
      // R1/R6/R7: first edge only arms, one measured period does not commit
      one_period(256);
      one_period(256);
      check("R7 no commit yet", 5, 1'b0, 1'b0, 1'b0);
      one_period(256);
      check("R1 R6 first commit", 2, 1'b1, 1'b0, 1'b0);
      // Boundaries of every window, overlaps, genuine 768, saturation
      for (int k = 0; k < 28; k++) begin
         string tag;
         tag = (bnd[k] > 1023) ? "R5 saturate" :
               (bnd[k] >= 736 && bnd[k] <= 800) ? "R9 genuine 768" :
               (bnd[k] == 160 || bnd[k] == 224) ? "R3 overlap" : "R3 R4 boundary";
         apply_and_check(bnd[k], tag);
      end
      // Sweep across the full range
      for (int p = 64; p <= 860; p += 17) apply_and_check(p, "R2 R8 sweep");
      // R6: alternating classifications must not commit
      apply_and_check(512, "R6 setup");
      one_period(256);
      one_period(384);
      one_period(256);
      one_period(384);
      check("R6 alternating holds", 4, 1'b1, 1'b0, 1'b0);
      // R4 after R6: error twice commits fallback
      apply_and_check(650, "R4 fallback");
      apply_and_check(150, "R8 half rate");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk_mst);
      if (!done) begin
         vectors++;
         fails++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule